// File: doc/BRIEF.md
# Dual-Channel Phase Detector with Lock Qualifier

This block sits between the divider chains and the charge pumps of a two-channel frequency synthesizer. All of its logic runs on the reference-oscillator clock. For each channel it takes a reference-divider strobe and a feedback-divider strobe. It works out which of the two arrived first, and it drives an up or a down request for as long as the trailing strobe is still missing. The mapping from "reference ahead" to up or down is set by a per-channel polarity input, which suits loop filters and VCOs of either slope. Every completed comparison ends with a one-cycle pulse on both pump lines, so there is no dead zone around zero error.

The phase error of each comparison is the number of clock cycles between the two strobes. The error counter saturates at its maximum. A coarse error of eight cycles or more clears the channel's lock flag at once. The flag is set again only after three comparisons in a row with an error of four cycles or less. A channel whose run input is low is powered down: its pump is released to high impedance, it ignores its strobes, and its lock status reads as locked. When the channel comes back, or after reset, the lead drive of its first comparison is cut to two cycles. A shared monitor pin carries either the AND of both lock statuses or one raw strobe picked by two test-select bits.

Top module: `phase_lock_det`

## Requirements
- R1: After the leading strobe of a comparison is sampled at a clock edge, the lead drive is asserted in each following cycle until the trailing strobe is sampled. With pol_i=1, a reference lead asserts pump_up_o and a feedback lead asserts pump_dn_o. With pol_i=0 the two are swapped. The drive lasts for the whole lead, however long, because the error counter saturates and does not wrap.
- R2: In the cycle after the edge that completes a comparison, both pump_up_o and pump_dn_o are high for exactly one cycle. This includes a zero-error comparison, where fr_i and fp_i are high on the same edge. pump_hiz_o is high exactly when neither pump line is high.
- R3: If the strobes of one comparison are eight or more cycles apart, chan_lock_o falls. It is low from the ninth cycle of the lead, or at the latest in the cycle after the comparison completes.
- R4: The error is the number of edges from the leading strobe to the trailing strobe. chan_lock_o rises in the cycle after the third consecutive comparison with an error of 4 or less. An error of 5 to 7 restarts the count of good comparisons but leaves the lock flag as it is. After reset the flag is low.
- R5: While run_i of a channel is low, that channel's pump_hiz_o is high, its chan_lock_o is high, and its strobes have no effect.
- R6: When lds_i=0, mon_o equals the AND of both chan_lock_o bits.
- R7: When lds_i=1, mon_o shows one raw strobe. t1_i selects the channel (0 selects channel 0, 1 selects channel 1). t2_i selects the strobe (0 selects fr_i, 1 selects fp_i).
- R8: After reset or after run_i rises, the lead drive of the channel's first comparison lasts at most 2 cycles. Its lock flag stays low until three good comparisons are complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fr_i | input | 2 | Reference-divider strobe per channel, sampled at each edge |
| fp_i | input | 2 | Feedback-divider strobe per channel, sampled at each edge |
| pol_i | input | 2 | Pump polarity per channel |
| run_i | input | 2 | 1 = channel active, 0 = power-saved |
| lds_i | input | 1 | Monitor select: 0 = combined lock, 1 = raw strobe |
| t1_i | input | 1 | Monitor channel select |
| t2_i | input | 1 | Monitor strobe select |
| pump_up_o | output | 2 | Drive-high request per channel |
| pump_dn_o | output | 2 | Drive-low request per channel |
| pump_hiz_o | output | 2 | Pump released per channel |
| chan_lock_o | output | 2 | Lock status per channel (high when power-saved) |
| mon_o | output | 1 | Shared monitor pin |

## Verification
The lead drive appears in the cycle after the edge that samples the leading strobe. It changes in step with the error count, one cycle per edge. The paired pulse and any change in the lock flag appear in the cycle after the edge that samples the trailing strobe. An early unlock shows in the ninth cycle of a lead. mon_o is purely combinational. The bench drives strobes on the falling edge and compares every output at the next falling edge, so each comparison lands in exactly the cycle given by this count of edges. Only mon_o is checked a short delay after its inputs change.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE      = 2'd0,
    PH_REF_AHEAD = 2'd1,
    PH_FB_AHEAD  = 2'd2
  } ph_state_e;

  typedef enum logic [1:0] {
    ERR_FINE   = 2'd0,
    ERR_MID    = 2'd1,
    ERR_COARSE = 2'd2
  } err_class_e;

  // Increment with saturation at lim.
  function automatic int sat_inc(input int v, input int lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // Sort an error count into its lock band.
  function automatic err_class_e classify(input int err, input int fine_th,
                                          input int coarse_th);
    if (err <= fine_th)        return ERR_FINE;
    else if (err >= coarse_th) return ERR_COARSE;
    else                       return ERR_MID;
  endfunction

endpackage

// File: rtl/pdl_pfd_chan.sv
module pdl_pfd_chan
  import pdl_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int WAKE_LIM  = 2,
  parameter int UNLOCK_TH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fr_i,
  input  logic             fp_i,
  input  logic             pol_i,
  output logic             up_o,
  output logic             dn_o,
  output logic             hiz_o,
  output logic             done_o,
  output logic [CNT_W-1:0] err_o,
  output logic             far_o,
  output logic             lead_drv_o,
  output logic             wake_o
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  ph_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pair_q, wake_q, wake_d;
  logic             gate_w, ref_drv, fb_drv, hi_drv, lo_drv;

  // Completion event: the trailing strobe has arrived.
  always_comb begin
    done_o = 1'b0;
    if (run_i) begin
      case (state_q)
        PH_IDLE:      done_o = fr_i & fp_i;
        PH_REF_AHEAD: done_o = fp_i;
        PH_FB_AHEAD:  done_o = fr_i;
        default:      done_o = 1'b0;
      endcase
    end
  end

  assign err_o = (state_q == PH_IDLE) ? '0 : cnt_q;
  assign far_o = run_i && (state_q != PH_IDLE) && (int'(cnt_q) >= UNLOCK_TH);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wake_d  = wake_q;
    if (!run_i) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
      wake_d  = 1'b1;
    end else begin
      if (done_o) wake_d = 1'b0;
      case (state_q)
        PH_IDLE: begin
          if (fr_i && !fp_i) begin
            state_d = PH_REF_AHEAD;
            cnt_d   = CNT_W'(1);
          end else if (fp_i && !fr_i) begin
            state_d = PH_FB_AHEAD;
            cnt_d   = CNT_W'(1);
          end
        end
        PH_REF_AHEAD: begin
          if (fp_i) begin
            state_d = PH_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = CNT_W'(sat_inc(int'(cnt_q), CNT_MAX));
          end
        end
        PH_FB_AHEAD: begin
          if (fr_i) begin
            state_d = PH_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = CNT_W'(sat_inc(int'(cnt_q), CNT_MAX));
          end
        end
        default: begin
          state_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      pair_q  <= 1'b0;
      wake_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pair_q  <= done_o;
      wake_q  <= wake_d;
    end
  end

  // First comparison after wake: lead drive stops past WAKE_LIM cycles.
  assign gate_w  = wake_q && (int'(cnt_q) > WAKE_LIM);
  assign ref_drv = (state_q == PH_REF_AHEAD) && !gate_w;
  assign fb_drv  = (state_q == PH_FB_AHEAD) && !gate_w;
  assign hi_drv  = pol_i ? ref_drv : fb_drv;
  assign lo_drv  = pol_i ? fb_drv : ref_drv;

  assign up_o       = run_i && (hi_drv || pair_q);
  assign dn_o       = run_i && (lo_drv || pair_q);
  assign hiz_o      = !(up_o || dn_o);
  assign lead_drv_o = ref_drv || fb_drv;
  assign wake_o     = wake_q;
endmodule

// File: rtl/pdl_lock_qual.sv
module pdl_lock_qual
  import pdl_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int LOCK_TH   = 4,
  parameter int UNLOCK_TH = 8,
  parameter int QUAL_N    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] err_i,
  input  logic             far_i,
  output logic             lock_o
);
  localparam int QW = $clog2(QUAL_N + 1);

  logic [QW-1:0] qual_q, qual_d;
  logic          lock_q, lock_d;
  err_class_e    cls_w;

  assign cls_w = classify(int'(err_i), LOCK_TH, UNLOCK_TH);

  always_comb begin
    lock_d = lock_q;
    qual_d = qual_q;
    if (!run_i) begin
      lock_d = 1'b0;
      qual_d = '0;
    end else if (far_i || (done_i && cls_w == ERR_COARSE)) begin
      lock_d = 1'b0;
      qual_d = '0;
    end else if (done_i) begin
      if (cls_w == ERR_FINE) begin
        qual_d = QW'(sat_inc(int'(qual_q), QUAL_N));
        if (int'(qual_q) + 1 >= QUAL_N) lock_d = 1'b1;
      end else begin
        qual_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      qual_q <= '0;
    end else begin
      lock_q <= lock_d;
      qual_q <= qual_d;
    end
  end

  // A power-saved channel reports locked.
  assign lock_o = !run_i || lock_q;
endmodule

// File: rtl/pdl_mon_sel.sv
module pdl_mon_sel (
  input  logic [1:0] fr_i,
  input  logic [1:0] fp_i,
  input  logic       lock_all_i,
  input  logic       lds_i,
  input  logic       t1_i,
  input  logic       t2_i,
  output logic       mon_o
);
  logic sel_w;

  always_comb begin
    sel_w = t2_i ? fp_i[t1_i] : fr_i[t1_i];
    mon_o = lds_i ? sel_w : lock_all_i;
  end
endmodule

// File: rtl/phase_lock_det.sv
module phase_lock_det #(
  parameter int CNT_W     = 5,
  parameter int LOCK_TH   = 4,
  parameter int UNLOCK_TH = 8,
  parameter int QUAL_N    = 3,
  parameter int WAKE_LIM  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] fr_i,
  input  logic [1:0] fp_i,
  input  logic [1:0] pol_i,
  input  logic [1:0] run_i,
  input  logic       lds_i,
  input  logic       t1_i,
  input  logic       t2_i,
  output logic [1:0] pump_up_o,
  output logic [1:0] pump_dn_o,
  output logic [1:0] pump_hiz_o,
  output logic [1:0] chan_lock_o,
  output logic       mon_o
);
  localparam int NCH = 2;

  logic [NCH-1:0]            done_w, far_w, lead_drv_w, wake_w;
  logic [NCH-1:0][CNT_W-1:0] err_w;
  logic                      lock_all_w;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pdl_pfd_chan #(
      .CNT_W(CNT_W), .WAKE_LIM(WAKE_LIM), .UNLOCK_TH(UNLOCK_TH)
    ) u_pfd (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i[c]),
      .fr_i(fr_i[c]), .fp_i(fp_i[c]), .pol_i(pol_i[c]),
      .up_o(pump_up_o[c]), .dn_o(pump_dn_o[c]), .hiz_o(pump_hiz_o[c]),
      .done_o(done_w[c]), .err_o(err_w[c]), .far_o(far_w[c]),
      .lead_drv_o(lead_drv_w[c]), .wake_o(wake_w[c])
    );

    pdl_lock_qual #(
      .CNT_W(CNT_W), .LOCK_TH(LOCK_TH), .UNLOCK_TH(UNLOCK_TH), .QUAL_N(QUAL_N)
    ) u_lock (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i[c]),
      .done_i(done_w[c]), .err_i(err_w[c]), .far_i(far_w[c]),
      .lock_o(chan_lock_o[c])
    );
  end

  assign lock_all_w = &chan_lock_o;

  pdl_mon_sel u_mon (
    .fr_i(fr_i), .fp_i(fp_i), .lock_all_i(lock_all_w),
    .lds_i(lds_i), .t1_i(t1_i), .t2_i(t2_i), .mon_o(mon_o)
  );
endmodule

// File: rtl/pdl_chk.sv
module pdl_chk #(
  parameter int CNT_W    = 5,
  parameter int WAKE_LIM = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [1:0]            run_i,
  input logic                  lds_i,
  input logic [1:0]            pump_up_o,
  input logic [1:0]            pump_dn_o,
  input logic [1:0]            pump_hiz_o,
  input logic [1:0]            chan_lock_o,
  input logic                  mon_o,
  input logic [1:0]            done_w,
  input logic [1:0]            far_w,
  input logic [1:0]            lead_drv_w,
  input logic [1:0]            wake_w,
  input logic [1:0][CNT_W-1:0] err_w
);
  a_r6_combined: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lds_i |-> (mon_o == (chan_lock_o[0] && chan_lock_o[1])));

  for (genvar c = 0; c < 2; c++) begin : g_a
    logic [7:0] len_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) len_q <= '0;
      else if (run_i[c] && lead_drv_w[c] && wake_w[c])
        len_q <= (len_q == 8'hFF) ? len_q : len_q + 8'd1;
      else len_q <= '0;
    end

    a_r2_pair_only_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pump_up_o[c] && pump_dn_o[c]) |-> $past(done_w[c]));

    a_r2_zero_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_w[c] && err_w[c] == '0) |=> ((pump_up_o[c] && pump_dn_o[c]) || !run_i[c]));

    a_r3_far_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[c] && far_w[c]) |=> (!run_i[c] || !chan_lock_o[c]));

    a_r4_rise_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[c] && !chan_lock_o[c] && !done_w[c]) |=> (!run_i[c] || !chan_lock_o[c]));

    a_r5_sleep_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i[c] |-> (pump_hiz_o[c] && chan_lock_o[c]));

    a_r8_wake_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i[c] && lead_drv_w[c] && wake_w[c]) |-> (int'(len_q) < WAKE_LIM));
  end
endmodule

bind phase_lock_det pdl_chk #(.CNT_W(CNT_W), .WAKE_LIM(WAKE_LIM)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .lds_i(lds_i),
  .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o), .pump_hiz_o(pump_hiz_o),
  .chan_lock_o(chan_lock_o), .mon_o(mon_o), .done_w(done_w), .far_w(far_w),
  .lead_drv_w(lead_drv_w), .wake_w(wake_w), .err_w(err_w)
);

// File: tb/phase_lock_det_tb.sv
`timescale 1ns/1ps
module phase_lock_det_tb_top;
  localparam int CNT_MAX   = 31;
  localparam int LOCK_TH   = 4;
  localparam int UNLOCK_TH = 8;
  localparam int QUAL_N    = 3;
  localparam int WAKE_LIM  = 2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] fr = '0, fp = '0, pol = 2'b11, run = 2'b11;
  logic       lds = 1'b0, t1 = 1'b0, t2 = 1'b0;
  logic [1:0] up, dn, hiz, lck;
  logic       mon;

  int nchk = 0, nfail = 0;
  bit finished = 0;
  int m_lock[2], m_qual[2], m_wake[2];

  always #2 clk = ~clk;

  phase_lock_det dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fr_i(fr), .fp_i(fp), .pol_i(pol),
    .run_i(run), .lds_i(lds), .t1_i(t1), .t2_i(t2),
    .pump_up_o(up), .pump_dn_o(dn), .pump_hiz_o(hiz),
    .chan_lock_o(lck), .mon_o(mon)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // {hi, lo} expected for a lead: dir 0 = reference ahead.
  function automatic logic [1:0] lead_pins(int dir, logic p, bit act);
    bit ref_lead = (dir == 0);
    logic hi = act && (p ? ref_lead : !ref_lead);
    logic lo = act && (p ? !ref_lead : ref_lead);
    return {hi, lo};
  endfunction

  function automatic int exp_lock(int c);
    return run[c] ? m_lock[c] : 1;
  endfunction

  task automatic check_locks(string req);
    for (int c = 0; c < 2; c++) check_eq(req, "chan_lock", int'(lck[c]), exp_lock(c));
    if (!lds) check_eq("R6", "mon combined", int'(mon), exp_lock(0) & exp_lock(1));
  endtask

  task automatic model_done(int c, int err);
    if (err >= UNLOCK_TH) begin m_lock[c] = 0; m_qual[c] = 0; end
    else if (err <= LOCK_TH) begin
      m_qual[c] = (m_qual[c] >= QUAL_N) ? QUAL_N : m_qual[c] + 1;
      if (m_qual[c] >= QUAL_N) m_lock[c] = 1;
    end else m_qual[c] = 0;
    m_wake[c] = 0;
  endtask

  // One comparison on channel c: dir 0 = fr first, 1 = fp first; k cycles apart.
  task automatic run_cmp(int c, int dir, int k);
    int o = 1 - c;
    logic [1:0] e;
    @(negedge clk);
    if (k == 0) begin fr[c] = 1'b1; fp[c] = 1'b1; end
    else if (dir == 0) fr[c] = 1'b1;
    else fp[c] = 1'b1;
    for (int j = 1; j <= k; j++) begin
      @(negedge clk);
      fr[c] = 1'b0; fp[c] = 1'b0;
      e = lead_pins(dir, pol[c], !(m_wake[c] != 0 && j > WAKE_LIM));
      check_eq(m_wake[c] != 0 ? "R8" : "R1", "pump_up lead", int'(up[c]), int'(e[1]));
      check_eq(m_wake[c] != 0 ? "R8" : "R1", "pump_dn lead", int'(dn[c]), int'(e[0]));
      check_eq("R2", "pump_hiz lead", int'(hiz[c]), int'(!(e[1] || e[0])));
      check_eq("R2", "other hiz", int'(hiz[o]), 1);
      if (j >= UNLOCK_TH + 1) begin m_lock[c] = 0; m_qual[c] = 0; end
      check_eq("R3", "lock during lead", int'(lck[c]), exp_lock(c));
      if (j == k) begin
        if (dir == 0) fp[c] = 1'b1; else fr[c] = 1'b1;
      end
    end
    @(negedge clk);
    fr[c] = 1'b0; fp[c] = 1'b0;
    check_eq("R2", "pair up", int'(up[c]), 1);
    check_eq("R2", "pair dn", int'(dn[c]), 1);
    model_done(c, (k > CNT_MAX) ? CNT_MAX : k);
    check_locks((k >= UNLOCK_TH) ? "R3" : "R4");
    @(negedge clk);
    check_eq("R2", "hiz after pair", int'(hiz[c]), 1);
  endtask

  task automatic set_run(int c, logic v);
    @(negedge clk);
    run[c] = v;
    if (v) begin m_lock[c] = 0; m_qual[c] = 0; m_wake[c] = 1; end
    @(negedge clk);
    if (!v) begin
      fr[c] = 1'b1;
      @(negedge clk);
      fr[c] = 1'b0;
      check_eq("R5", "sleep hiz", int'(hiz[c]), 1);
      @(negedge clk);
      check_eq("R5", "sleep hiz after strobe", int'(hiz[c]), 1);
      check_locks("R5");
    end else begin
      check_eq("R8", "wake hiz", int'(hiz[c]), 1);
      check_locks("R8");
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0711));
    for (int c = 0; c < 2; c++) begin m_lock[c] = 0; m_qual[c] = 0; m_wake[c] = 1; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R2", "reset hiz", int'(hiz), 3);
    check_eq("R4", "reset lock", int'(lck), 0);
    check_eq("R6", "reset mon", int'(mon), 0);

    // Wake-limited first comparison, then qualification of channel 0.
    run_cmp(0, 0, 5);
    run_cmp(0, 0, 4);
    run_cmp(0, 0, 4);
    run_cmp(0, 0, 4);
    // Channel 1 by zero-error comparisons; combined goes high.
    run_cmp(1, 0, 0);
    run_cmp(1, 1, 1);
    run_cmp(1, 0, 0);
    run_cmp(1, 0, 0);
    // Mid error keeps lock; coarse errors drop it.
    run_cmp(0, 1, 7);
    run_cmp(0, 0, 8);
    for (int i = 0; i < 3; i++) run_cmp(0, 0, 1);
    run_cmp(0, 1, 12);
    // Polarity swap and long saturated lead.
    pol = 2'b00;
    run_cmp(0, 1, 3);
    run_cmp(0, 0, 3);
    run_cmp(1, 1, 40);
    pol = 2'b11;
    // Power saving and wake on channel 1.
    set_run(1, 1'b0);
    set_run(1, 1'b1);
    run_cmp(1, 0, 6);
    // Monitor multiplexer with both channels asleep.
    set_run(0, 1'b0);
    set_run(1, 1'b0);
    @(negedge clk);
    lds = 1'b1;
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 16; p++) begin
        @(negedge clk);
        t1 = s[0]; t2 = s[1];
        fr = p[1:0]; fp = p[3:2];
        #1;
        check_eq("R7", "mon strobe", int'(mon), int'(t2 ? fp[t1] : fr[t1]));
      end
    end
    @(negedge clk);
    fr = '0; fp = '0; lds = 1'b0;
    #1;
    check_eq("R6", "mon both asleep", int'(mon), 1);
    set_run(0, 1'b1);
    set_run(1, 1'b1);

    // Random comparisons mixed with sleep/wake.
    for (int i = 0; i < 250; i++) begin
      int c = int'($urandom % 2);
      if ($urandom % 25 == 0) set_run(c, !run[c]);
      else if (!run[c]) set_run(c, 1'b1);
      else begin
        int k = ($urandom % 10 == 0) ? 33 + int'($urandom % 6) : int'($urandom % 11);
        pol[c] = $urandom % 2;
        run_cmp(c, int'($urandom % 2), k);
      end
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule